// File: doc/BRIEF.md
# Lowest Set Bit Isolation Unit

This execution unit takes one integer source word per transaction and returns a word in which only the lowest set bit of that source remains. Every other bit is cleared. Alongside the result it returns sign, zero, carry and overflow flags, plus auxiliary-carry and parity outputs that are always zero. It also returns a write enable for those flags and an undefined-opcode fault.

The operand width depends on the execution mode. In 64-bit mode the width-select bit chooses between 32 and 64 bits. In protected mode the width is always 32 bits and the width-select bit is ignored. Issue in real or virtual-8086 mode raises the fault, and so does any nonzero vector-length field. A faulting transaction produces a zero result, all flags zero and no flag write.

Both sides of the unit use a valid/ready handshake. A transaction is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its outputs appear one cycle later with `out_valid` high. They stay there, unchanged, until a clock edge where `out_ready` is also high. The unit holds one result. `in_ready` is high when the output register is empty or is being drained in the same cycle, so back-pressure from the consumer reaches the producer without any loss.

Top module: `lsb_iso_unit`

## Requirements
- R1: The result equals the source ANDed with its two's-complement negation, taken at the active width. At most one result bit is set.
- R2: The width is 64 bits only when the mode code is 3 (64-bit) and `in_wide` is 1. Otherwise the low 32 source bits are used and result bits 63..32 are zero.
- R3: `out_zf` is 1 exactly when the result of a non-faulting transaction is zero. `out_sf` equals result bit 63 at 64-bit width and result bit 31 at 32-bit width.
- R4: `out_cf` is 1 exactly when the source at the active width is nonzero. `out_of`, `out_af` and `out_pf` are always 0.
- R5: A fault is raised when `in_len` is nonzero or the mode code is 0 (real) or 1 (virtual-8086). A faulting transaction sets `out_fault` to 1, drives the result and all flags to 0, and drives `out_flag_we` to 0.
- R6: `out_flag_we` is 1 for every non-faulting transaction. Mode code 2 (protected) with `in_len` of 0 never faults, and there `in_wide` has no effect.
- R7: An accepted transaction appears on the outputs one clock edge later with `out_valid` high. After reset `out_valid` is 0.
- R8: While `out_valid` is high and `out_ready` is low, the outputs hold their values and `in_ready` is low. No input is taken during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Source transaction present |
| in_ready | output | 1 | Unit can accept a transaction |
| in_src | input | 64 | Source word |
| in_mode | input | 2 | Execution mode: 0 real, 1 virtual-8086, 2 protected, 3 64-bit |
| in_wide | input | 1 | Requests 64-bit width (honoured only in 64-bit mode) |
| in_len | input | 2 | Vector-length field, must be zero |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 64 | Isolated lowest set bit |
| out_sf | output | 1 | Sign flag |
| out_zf | output | 1 | Zero flag |
| out_cf | output | 1 | Carry flag |
| out_of | output | 1 | Overflow flag, always 0 |
| out_af | output | 1 | Auxiliary-carry flag, always 0 |
| out_pf | output | 1 | Parity flag, always 0 |
| out_flag_we | output | 1 | Flags are to be written |
| out_fault | output | 1 | Undefined-opcode fault |

## Verification
The assertions take for granted that the producer keeps `in_valid` and the source fields steady until they are accepted. They also assume that every input is a known value whenever `in_valid` is high. The hold and ready properties have meaning only under that discipline. The bench drives inputs on falling edges and changes them only after an acceptance. While the output is stalled it presents a second transaction and keeps it steady, so back-pressure is exercised under the same input contract.

// File: rtl/lsb_iso_pkg.sv
package lsb_iso_pkg;

  typedef enum logic [1:0] {
    MODE_REAL = 2'd0,
    MODE_V86  = 2'd1,
    MODE_PROT = 2'd2,
    MODE_LONG = 2'd3
  } exec_mode_e;

  typedef struct packed {
    logic sf;
    logic zf;
    logic cf;
    logic of;
    logic af;
    logic pf;
  } iso_flags_t;

endpackage

// File: rtl/lsb_iso_cfg.sv
module lsb_iso_cfg
  import lsb_iso_pkg::*;
#(
  parameter int LEN_W = 2
) (
  input  logic [1:0]       mode,
  input  logic             wide_sel,
  input  logic [LEN_W-1:0] len,
  output logic             use_wide,
  output logic             fault
);

  exec_mode_e mode_e;
  logic       mode_bad;

  assign mode_e = exec_mode_e'(mode);

  always_comb begin
    mode_bad = 1'b0;
    case (mode_e)
      MODE_REAL, MODE_V86: mode_bad = 1'b1;
      default:             mode_bad = 1'b0;
    endcase
  end

  // width select only counts in 64-bit mode
  assign use_wide = (mode_e == MODE_LONG) && wide_sel;
  assign fault    = mode_bad || (len != '0);

endmodule

// File: rtl/lsb_iso_core.sv
module lsb_iso_core
  import lsb_iso_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32
) (
  input  logic [DATA_W-1:0] src,
  input  logic              use_wide,
  output logic [DATA_W-1:0] result,
  output iso_flags_t        flags
);

  localparam int UPPER_W = DATA_W - NARROW_W;
  localparam logic [DATA_W-1:0] NARROW_MASK = {{UPPER_W{1'b0}}, {NARROW_W{1'b1}}};

  logic [DATA_W-1:0] src_act;
  logic [DATA_W-1:0] neg_src;

  assign src_act = use_wide ? src : (src & NARROW_MASK);
  assign neg_src = -src_act;
  assign result  = neg_src & src_act;

  always_comb begin
    flags    = '0;
    flags.zf = (result == '0);
    flags.cf = (src_act != '0);
    flags.sf = use_wide ? result[DATA_W-1] : result[NARROW_W-1];
  end

endmodule

// File: rtl/lsb_iso_unit.sv
module lsb_iso_unit
  import lsb_iso_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32,
  parameter int LEN_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_src,
  input  logic [1:0]        in_mode,
  input  logic              in_wide,
  input  logic [LEN_W-1:0]  in_len,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_sf,
  output logic              out_zf,
  output logic              out_cf,
  output logic              out_of,
  output logic              out_af,
  output logic              out_pf,
  output logic              out_flag_we,
  output logic              out_fault
);

  logic              use_wide;
  logic              fault_c;
  logic [DATA_W-1:0] res_c;
  iso_flags_t        flags_c;

  logic              v_q;
  logic [DATA_W-1:0] res_q;
  iso_flags_t        flags_q;
  logic              fault_q;
  logic              in_fire;

  lsb_iso_cfg #(.LEN_W(LEN_W)) u_cfg (
    .mode     (in_mode),
    .wide_sel (in_wide),
    .len      (in_len),
    .use_wide (use_wide),
    .fault    (fault_c)
  );

  lsb_iso_core #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_core (
    .src      (in_src),
    .use_wide (use_wide),
    .result   (res_c),
    .flags    (flags_c)
  );

  assign in_ready = !v_q || out_ready;
  assign in_fire  = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q     <= 1'b0;
      res_q   <= '0;
      flags_q <= '0;
      fault_q <= 1'b0;
    end else begin
      if (in_fire) begin
        v_q     <= 1'b1;
        fault_q <= fault_c;
        res_q   <= fault_c ? '0 : res_c;
        flags_q <= fault_c ? iso_flags_t'('0) : flags_c;
      end else if (out_ready) begin
        v_q <= 1'b0;
      end
    end
  end

  assign out_valid   = v_q;
  assign out_result  = res_q;
  assign out_sf      = flags_q.sf;
  assign out_zf      = flags_q.zf;
  assign out_cf      = flags_q.cf;
  assign out_of      = flags_q.of;
  assign out_af      = flags_q.af;
  assign out_pf      = flags_q.pf;
  assign out_fault   = fault_q;
  assign out_flag_we = !fault_q;

  // R1
  onehot_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0(out_result));

  // R5
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fault) |-> (!out_flag_we && out_result == '0 && !out_cf && !out_zf));

  // R4
  zero_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_fault) |-> (out_zf != out_cf));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_fault)));

  // R8
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

endmodule

// File: tb/lsb_iso_unit_tb.sv
module lsb_iso_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_src = '0;
  logic [1:0]  in_mode = '0;
  logic        in_wide = 1'b0;
  logic [1:0]  in_len = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_result;
  logic        out_sf, out_zf, out_cf, out_of, out_af, out_pf, out_flag_we, out_fault;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lsb_iso_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_src(in_src), .in_mode(in_mode), .in_wide(in_wide), .in_len(in_len),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_sf(out_sf), .out_zf(out_zf), .out_cf(out_cf), .out_of(out_of),
    .out_af(out_af), .out_pf(out_pf), .out_flag_we(out_flag_we), .out_fault(out_fault)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compare all outputs against the arithmetic model
  task automatic expect_out(input logic [63:0] s, input logic [1:0] m, input logic w,
                            input logic [1:0] l);
    logic        flt, wd;
    logic [63:0] sa, r;
    flt = (l != 2'd0) || (m < 2'd2);
    wd  = (m == 2'd3) && w;
    sa  = wd ? s : {32'h0, s[31:0]};
    r   = flt ? 64'h0 : (sa & (~sa + 64'd1));
    chk("R7 out_valid", 64'(out_valid), 64'd1);
    chk("R1 R2 R5 result", out_result, r);
    chk("R5 fault", 64'(out_fault), 64'(flt));
    chk("R6 flag_we", 64'(out_flag_we), 64'(!flt));
    chk("R3 zf", 64'(out_zf), 64'(!flt && r == 64'h0));
    chk("R3 sf", 64'(out_sf), 64'(flt ? 1'b0 : (wd ? r[63] : r[31])));
    chk("R4 cf", 64'(out_cf), 64'(!flt && sa != 64'h0));
    chk("R4 of af pf", {61'h0, out_of, out_af, out_pf}, 64'h0);
  endtask

  task automatic run_one(input logic [63:0] s, input logic [1:0] m, input logic w,
                         input logic [1:0] l);
    in_src = s; in_mode = m; in_wide = w; in_len = l; in_valid = 1'b1;
    @(negedge clk);
    expect_out(s, m, w, l);
  endtask

  task automatic sweep(input logic [63:0] s);
    for (int m = 0; m < 4; m++)
      for (int w = 0; w < 2; w++)
        for (int l = 0; l < 4; l++)
          run_one(s, 2'(m), 1'(w), 2'(l));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R7 reset out_valid", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 idle out_valid", 64'(out_valid), 64'd0);

    sweep(64'h0);
    sweep(64'hFFFF_FFFF_FFFF_FFFF);
    sweep(64'h0000_0000_8000_0000);
    sweep(64'h8000_0000_0000_0000);
    sweep(64'h8000_0000_0001_0000);
    for (int b = 0; b < 64; b++) sweep(64'd1 << b);
    for (int k = 0; k < 40; k++) sweep({$urandom(), $urandom()});
    in_valid = 1'b0;
    @(negedge clk);
    chk("R7 drained out_valid", 64'(out_valid), 64'd0);

    // R8 back-pressure: first word stalls, second waits
    out_ready = 1'b0;
    run_one(64'h0000_00F0_0000_0000, 2'd3, 1'b1, 2'd0);
    in_src = 64'h0000_0000_0000_0C00; in_mode = 2'd2; in_wide = 1'b1; in_len = 2'd0;
    chk("R8 in_ready low", 64'(in_ready), 64'd0);
    @(negedge clk);
    chk("R8 held result", out_result, 64'h0000_0010_0000_0000);
    chk("R8 held valid", 64'(out_valid), 64'd1);
    @(negedge clk);
    chk("R8 held result 2", out_result, 64'h0000_0010_0000_0000);
    out_ready = 1'b1;
    @(negedge clk);
    expect_out(64'h0000_0000_0000_0C00, 2'd2, 1'b1, 2'd0);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R7 final out_valid", 64'(out_valid), 64'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule